// File: doc/BRIEF.md
# Address Breakpoint Unit

This block watches the address bus of an 8-bit CPU core and requests a break when the bus reaches a 16-bit address held by software. The address is loaded a byte at a time through a small register port. Each byte is compared against its half of the bus, and a hit needs every byte to agree. The break request goes to the system integration logic, which turns it into a break interrupt.

When the break request is raised depends on the kind of bus cycle that hit. A hit on an opcode fetch raises the request in the same cycle, so the fetched instruction never executes before the break routine runs. A hit on an operand fetch is held internally and raised at the next instruction boundary, so the instruction that owns the operand finishes first. Software can also force a break by writing 1 to the active bit. That request is held until the next instruction boundary in the same way. Once taken, the break stays asserted until software clears the active bit.

Top module: `addr_brk_unit`

## Requirements
- R1: After reset every register reads 0x00 (offsets 0x0, 0x3, 0x9, 0xA, 0xB) and brk_o is 0.
- R2: A write takes effect on the clock edge that samples reg_we_i. Offset 0x9 holds the upper address byte and offset 0xA the lower byte; both are full read/write. Offset 0x3 keeps only bit 7. At offset 0xB, bit 7 is the enable and bit 6 is the active flag, and bits 5..0 read 0.
- R3: While the enable bit is 0, no bus cycle raises brk_o or sets the active flag.
- R4: Suppose bus_cyc_i=1, fetch_op_i=1, the unit is enabled and bus_addr_i equals the stored address. Then brk_o is 1 in that same cycle, and the active flag reads 1 after that edge.
- R5: An address that differs from the stored one in only the upper byte, or only the lower byte, raises no break.
- R6: A matching cycle with fetch_op_i=0 leaves brk_o at 0 until the next cycle with insn_bnd_i=1. brk_o is 1 in that boundary cycle, and the active flag is set at its edge.
- R7: Writing offset 0xB with bit 6=1 does not raise brk_o at once. brk_o rises in the next insn_bnd_i cycle, and the active flag is set at that edge.
- R8: While the active flag and the enable are both 1, brk_o stays 1. Writing offset 0xB with bit 6=0 clears the active flag and discards any held operand or software request, so a later boundary raises nothing.
- R9: Offset 0x0 bit 0 is a sticky status bit that is set when a break is taken. Writing 0 to that bit clears it; writing 1 to it has no effect. Bits 7..1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| bus_addr_i | input | 16 | CPU address bus |
| bus_cyc_i | input | 1 | A valid bus cycle is present |
| fetch_op_i | input | 1 | The current cycle is an opcode fetch |
| insn_bnd_i | input | 1 | An instruction boundary is reached this cycle |
| brk_o | output | 1 | Break request |

## Verification
The assertions assume that an instruction-boundary strobe never falls in the same cycle as an operand fetch. They also assume that register writes and bus cycles arrive as single-cycle pulses on a clean clock. The directed stimulus keeps the bus idle during register accesses. It clears every bus input just after each active edge, so every pulse lasts exactly one cycle. Boundary strobes come only in cycles of their own, after the fetch cycle they follow.

// File: rtl/addr_brk_pkg.sv
package addr_brk_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 4;

  localparam logic [OFF_W-1:0] OFF_STAT = 4'h0;
  localparam logic [OFF_W-1:0] OFF_FCTL = 4'h3;
  localparam logic [OFF_W-1:0] OFF_AHI  = 4'h9;
  localparam logic [OFF_W-1:0] OFF_ALO  = 4'hA;
  localparam logic [OFF_W-1:0] OFF_CTL  = 4'hB;

  localparam int CTL_EN_BIT  = 7;
  localparam int CTL_ACT_BIT = 6;
  localparam int STAT_BIT    = 0;
  localparam int FCTL_BIT    = 7;
endpackage

// File: rtl/addr_brk_cmp.sv
module addr_brk_cmp #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [ADDR_W-1:0] ref_addr_i,
  output logic              hit_o
);
  localparam int NB = ADDR_W / BYTE_W;

  logic [NB-1:0] byte_eq;

  for (genvar g = 0; g < NB; g++) begin : g_byte
    assign byte_eq[g] = (bus_addr_i[g*BYTE_W +: BYTE_W] == ref_addr_i[g*BYTE_W +: BYTE_W]);
  end

  assign hit_o = &byte_eq;
endmodule

// File: rtl/addr_brk_regs.sv
module addr_brk_regs
  import addr_brk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OFF_W-1:0]  reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              act_i,
  input  logic              take_i,
  output logic [ADDR_W-1:0] ref_addr_o,
  output logic              en_o,
  output logic [BYTE_W-1:0] rdata_o
);
  localparam int NB = ADDR_W / BYTE_W;

  logic [NB-1:0][BYTE_W-1:0] addr_byte_q;
  logic                      en_q;
  logic                      fctl_q;
  logic                      stat_q;
  logic [BYTE_W-1:0]         byte_rd;
  logic                      byte_sel;

  // byte k sits at OFF_ALO - k, lower byte highest offset
  for (genvar k = 0; k < NB; k++) begin : g_areg
    localparam logic [OFF_W-1:0] OFF_K = OFF_W'(OFF_ALO - OFF_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              addr_byte_q[k] <= '0;
      else if (reg_we_i && reg_addr_i == OFF_K) addr_byte_q[k] <= reg_wdata_i;
    end
    assign ref_addr_o[k*BYTE_W +: BYTE_W] = addr_byte_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      fctl_q <= 1'b0;
    end else if (reg_we_i) begin
      if (reg_addr_i == OFF_CTL)  en_q   <= reg_wdata_i[CTL_EN_BIT];
      if (reg_addr_i == OFF_FCTL) fctl_q <= reg_wdata_i[FCTL_BIT];
    end
  end

  // set wins over a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    stat_q <= 1'b0;
    else if (take_i)                stat_q <= 1'b1;
    else if (reg_we_i && reg_addr_i == OFF_STAT && !reg_wdata_i[STAT_BIT])
                                    stat_q <= 1'b0;
  end

  always_comb begin
    byte_rd  = '0;
    byte_sel = 1'b0;
    for (int k = 0; k < NB; k++) begin
      if (reg_addr_i == OFF_W'(OFF_ALO - OFF_W'(k))) begin
        byte_rd  = addr_byte_q[k];
        byte_sel = 1'b1;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (byte_sel) begin
      rdata_o = byte_rd;
    end else begin
      unique case (reg_addr_i)
        OFF_CTL: begin
          rdata_o[CTL_EN_BIT]  = en_q;
          rdata_o[CTL_ACT_BIT] = act_i;
        end
        OFF_FCTL: rdata_o[FCTL_BIT] = fctl_q;
        OFF_STAT: rdata_o[STAT_BIT] = stat_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/addr_brk_seq.sv
module addr_brk_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hit_i,
  input  logic fetch_op_i,
  input  logic insn_bnd_i,
  input  logic ctl_we_i,
  input  logic ctl_act_wr_i,
  output logic act_o,
  output logic take_o,
  output logic brk_o
);
  logic act_q, opnd_pend_q, sw_pend_q;
  logic match, op_hit, opnd_hit, bnd_fire, soft_set, soft_clr;

  always_comb begin
    match    = en_i & hit_i;
    op_hit   = match & fetch_op_i;
    opnd_hit = match & ~fetch_op_i;
    bnd_fire = en_i & insn_bnd_i & (opnd_pend_q | sw_pend_q);
    soft_set = ctl_we_i & ctl_act_wr_i;
    soft_clr = ctl_we_i & ~ctl_act_wr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      opnd_pend_q <= 1'b0;
      sw_pend_q   <= 1'b0;
    end else begin
      if (op_hit || bnd_fire) act_q <= 1'b1;
      else if (soft_clr)      act_q <= 1'b0;

      if (opnd_hit)                     opnd_pend_q <= 1'b1;
      else if (insn_bnd_i || soft_clr)  opnd_pend_q <= 1'b0;

      if (soft_set)                     sw_pend_q <= 1'b1;
      else if (insn_bnd_i || soft_clr)  sw_pend_q <= 1'b0;
    end
  end

  assign take_o = op_hit | bnd_fire;
  assign act_o  = act_q;
  assign brk_o  = en_i & (act_q | take_o);
endmodule

// File: rtl/addr_brk_unit.sv
module addr_brk_unit
  import addr_brk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OFF_W-1:0]  reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_cyc_i,
  input  logic              fetch_op_i,
  input  logic              insn_bnd_i,
  output logic              brk_o
);
  logic [ADDR_W-1:0] ref_addr;
  logic              en, act, take, addr_eq, ctl_we;

  assign ctl_we = reg_we_i && (reg_addr_i == OFF_CTL);

  addr_brk_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_we_i   (reg_we_i),
    .act_i      (act),
    .take_i     (take),
    .ref_addr_o (ref_addr),
    .en_o       (en),
    .rdata_o    (reg_rdata_o)
  );

  addr_brk_cmp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_cmp (
    .bus_addr_i(bus_addr_i),
    .ref_addr_i(ref_addr),
    .hit_o     (addr_eq)
  );

  addr_brk_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .hit_i       (addr_eq & bus_cyc_i),
    .fetch_op_i  (fetch_op_i),
    .insn_bnd_i  (insn_bnd_i),
    .ctl_we_i    (ctl_we),
    .ctl_act_wr_i(reg_wdata_i[CTL_ACT_BIT]),
    .act_o       (act),
    .take_o      (take),
    .brk_o       (brk_o)
  );
endmodule

// File: rtl/addr_brk_chk.sv
module addr_brk_chk
  import addr_brk_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OFF_W-1:0]  reg_addr_i,
  input logic [BYTE_W-1:0] reg_wdata_i,
  input logic              reg_we_i,
  input logic [BYTE_W-1:0] reg_rdata_o,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_cyc_i,
  input logic              fetch_op_i,
  input logic              insn_bnd_i,
  input logic              brk_o,
  input logic [ADDR_W-1:0] ref_addr,
  input logic              en,
  input logic              act,
  input logic              take
);
  logic opc_hit;
  assign opc_hit = en && bus_cyc_i && fetch_op_i && (bus_addr_i == ref_addr);

  AST_WR_HI_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == OFF_AHI |=> ref_addr[ADDR_W-1 -: BYTE_W] == $past(reg_wdata_i)); // R2
  AST_CTL_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i == OFF_CTL |-> reg_rdata_o[5:0] == 6'd0); // R2
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !brk_o); // R3
  AST_OPC_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opc_hit |-> brk_o); // R4
  AST_OPC_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opc_hit |=> act); // R4
  AST_NO_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act && !insn_bnd_i && !opc_hit |-> !brk_o); // R6
  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en && act |-> brk_o); // R8
  AST_SW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == OFF_CTL && !reg_wdata_i[CTL_ACT_BIT] && !take |=> !act); // R8
endmodule

bind addr_brk_unit addr_brk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_we_i   (reg_we_i),
  .reg_rdata_o(reg_rdata_o),
  .bus_addr_i (bus_addr_i),
  .bus_cyc_i  (bus_cyc_i),
  .fetch_op_i (fetch_op_i),
  .insn_bnd_i (insn_bnd_i),
  .brk_o      (brk_o),
  .ref_addr   (ref_addr),
  .en         (en),
  .act        (act),
  .take       (take)
);

// File: tb/addr_brk_unit_test.sv
module addr_brk_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  wdata = '0;
  logic        we = 1'b0;
  logic [7:0]  rdata;
  logic [15:0] bus_addr = '0;
  logic        bus_cyc = 1'b0;
  logic        fetch_op = 1'b0;
  logic        bnd = 1'b0;
  logic        brk;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  addr_brk_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_addr_i(reg_addr), .reg_wdata_i(wdata), .reg_we_i(we), .reg_rdata_o(rdata),
    .bus_addr_i(bus_addr), .bus_cyc_i(bus_cyc), .fetch_op_i(fetch_op),
    .insn_bnd_i(bnd), .brk_o(brk)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = rdata;
  endtask

  // one bus cycle; returns brk_o sampled mid-cycle, inputs cleared after the edge
  task automatic cyc(input logic [15:0] a, input logic c, input logic op,
                     input logic b, output logic k);
    @(negedge clk);
    bus_addr = a; bus_cyc = c; fetch_op = op; bnd = b;
    #5 k = brk;
    @(posedge clk);
    #1 bus_cyc = 1'b0; fetch_op = 1'b0; bnd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(4'h0, d); chk("R1 stat", d, 8'h00);
    rd(4'h3, d); chk("R1 fctl", d, 8'h00);
    rd(4'h9, d); chk("R1 ahi", d, 8'h00);
    rd(4'hA, d); chk("R1 alo", d, 8'h00);
    rd(4'hB, d); chk("R1 ctl", d, 8'h00);
    chk("R1 brk", brk, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(4'h9, 8'h12); rd(4'h9, d); chk("R2 ahi", d, 8'h12);
    wr(4'hA, 8'h34); rd(4'hA, d); chk("R2 alo", d, 8'h34);
    wr(4'h3, 8'hFF); rd(4'h3, d); chk("R2 fctl", d, 8'h80);
    wr(4'h3, 8'h00); rd(4'h3, d); chk("R2 fctl clr", d, 8'h00);
    wr(4'hB, 8'h3F); rd(4'hB, d); chk("R2 ctl low bits", d, 8'h00);
    wr(4'h0, 8'hFE); rd(4'h0, d); chk("R9 stat reserved", d, 8'h00);
  endtask

  task automatic t_disabled();
    logic k; logic [7:0] d;
    wr(4'hB, 8'h00);
    cyc(16'h1234, 1'b1, 1'b1, 1'b0, k); chk("R3 brk off opcode", k, 0);
    cyc(16'h1234, 1'b1, 1'b0, 1'b0, k);
    cyc(16'h0000, 1'b0, 1'b0, 1'b1, k); chk("R3 brk off boundary", k, 0);
    rd(4'hB, d); chk("R3 act clear", d, 8'h00);
  endtask

  task automatic t_halves();
    logic k;
    wr(4'hB, 8'h80);
    cyc(16'h1235, 1'b1, 1'b1, 1'b0, k); chk("R5 low differs", k, 0);
    cyc(16'h1334, 1'b1, 1'b1, 1'b0, k); chk("R5 high differs", k, 0);
    cyc(16'h1234, 1'b0, 1'b1, 1'b0, k); chk("R5 no bus cycle", k, 0);
  endtask

  task automatic t_opcode();
    logic k; logic [7:0] d;
    wr(4'h0, 8'h00);
    cyc(16'h1234, 1'b1, 1'b1, 1'b0, k); chk("R4 same cycle", k, 1);
    rd(4'hB, d); chk("R4 act set", d, 8'hC0);
    chk("R8 sticky", brk, 1);
    rd(4'h0, d); chk("R9 stat set", d, 8'h01);
    wr(4'h0, 8'h01); rd(4'h0, d); chk("R9 write 1 no effect", d, 8'h01);
    wr(4'h0, 8'h00); rd(4'h0, d); chk("R9 write 0 clears", d, 8'h00);
    wr(4'hB, 8'h80); rd(4'hB, d); chk("R8 sw clear", d, 8'h80);
    chk("R8 brk dropped", brk, 0);
  endtask

  task automatic t_operand();
    logic k; logic [7:0] d;
    cyc(16'h1234, 1'b1, 1'b0, 1'b0, k); chk("R6 no brk on operand", k, 0);
    cyc(16'h2000, 1'b1, 1'b0, 1'b0, k); chk("R6 held until boundary", k, 0);
    cyc(16'h0000, 1'b0, 1'b0, 1'b1, k); chk("R6 brk at boundary", k, 1);
    rd(4'hB, d); chk("R6 act set", d, 8'hC0);
    wr(4'hB, 8'h80);
  endtask

  task automatic t_soft();
    logic k; logic [7:0] d;
    wr(4'hB, 8'hC0);
    rd(4'hB, d); chk("R7 act not yet", d, 8'h80);
    chk("R7 no brk before boundary", brk, 0);
    cyc(16'h0000, 1'b0, 1'b0, 1'b1, k); chk("R7 brk at boundary", k, 1);
    rd(4'hB, d); chk("R7 act set", d, 8'hC0);
    wr(4'hB, 8'h80);
  endtask

  task automatic t_cancel();
    logic k; logic [7:0] d;
    wr(4'hB, 8'hC0);
    wr(4'hB, 8'h80);
    cyc(16'h0000, 1'b0, 1'b0, 1'b1, k); chk("R8 soft request discarded", k, 0);
    cyc(16'h1234, 1'b1, 1'b0, 1'b0, k);
    wr(4'hB, 8'h80);
    cyc(16'h0000, 1'b0, 1'b0, 1'b1, k); chk("R8 operand request discarded", k, 0);
    rd(4'hB, d); chk("R8 act stays clear", d, 8'h80);
  endtask

  initial begin
    #(20 * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_disabled();
    t_halves();
    t_opcode();
    t_operand();
    t_soft();
    t_cancel();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule